// File: doc/BRIEF.md
# Track Power and Capacitor-Discharge Point Controller

This block is the control state machine that sits between a command decoder and the hardware that powers model railway track and fires point (turnout) motors from a capacitor-discharge unit. It takes one-cycle command strobes for power on, power off and point firing, and level inputs for a short-circuit detector, a charge-ready indicator and a motion-finished indicator. It drives the track enable, the discharge-unit enable, one drive enable per point motor and a fault lamp. It also hands a single status byte, with a one-cycle valid strobe, to whatever serialises status messages back to the host.

Power comes up only on an explicit on command. A short while powered drops everything and reports a fault. Clearing the short is reported, but power stays down until the next on command. Firing a point is interlocked: the unit must report charged first. Each firing reports when the motor stops and again when the unit has recharged. Requests that break this interlock are dropped and flagged.

Top module: `trk_pwr_cdu_ctrl`

## Requirements
- R1: After reset, track enable, discharge enable, every point drive, the fault lamp, the error strobe and the status valid strobe are all low.
- R2: An on command while unpowered raises track enable and discharge enable one cycle later. The unit then starts charging, and all point drives stay low.
- R3: A short seen while powered drops track enable, discharge enable and all point drives one cycle later, emits status byte 0x07, and lights the fault lamp.
- R4: When the short input returns low after a fault, status byte 0x06 is emitted. Track power stays off until an on command, and an on command while the short is still present is ignored.
- R5: While charging, charge-ready makes the unit ready and emits the charged byte 0x28. This is bit 7 = 0, bits 6:3 = 0101, and bits 2:0 = unit number 0.
- R6: A fire request while ready, with an index below NUM_POINTS, raises exactly one drive, bit number equal to the index, one cycle later. The drive holds until motion-done. Motion-done then drops it and emits the pointed byte 0x20, which is bits 6:3 = 0100 and bits 2:0 = unit number 0.
- R7: After a firing, the unit recharges. The next charge-ready emits 0x28 again and makes it ready for another request.
- R8: A fire request when not ready, or with an index at or above NUM_POINTS, is ignored. It pulses the error output for one cycle and changes no drive.
- R9: An off command drops track enable, discharge enable and all point drives one cycle later, whatever the state. Inputs other than on then have no effect.
- R10: An off command takes priority over an on command or a short in the same cycle. Neither a power-up nor a fault report results.
- R11: The fault lamp stays lit from the short until the next accepted on command. An off command does not clear it.
- R12: At most one status byte is emitted per cycle, and each valid strobe lasts one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_on_i | input | 1 | Power-on command strobe |
| cmd_off_i | input | 1 | Power-off command strobe |
| fire_req_i | input | 1 | Point fire request strobe |
| fire_idx_i | input | IDX_W | Index of the point motor to fire |
| short_i | input | 1 | Short-circuit detected (level) |
| charged_i | input | 1 | Discharge capacitor charged (level) |
| motion_done_i | input | 1 | Point motor has stopped (level) |
| track_en_o | output | 1 | Track power enable |
| cdu_en_o | output | 1 | Discharge unit enable |
| point_drv_o | output | NUM_POINTS | Point motor drive enables |
| fault_lamp_o | output | 1 | Fault indicator |
| req_err_o | output | 1 | Rejected fire request strobe |
| stat_vld_o | output | 1 | Status byte valid strobe |
| stat_byte_o | output | 8 | Status byte to send |

## Verification
Two functions can fall in the same cycle: the off command and the reaction to a short, or the off command and an on command. The bench provokes the first by asserting off and short together while powered and ready. The second is provoked by driving on and off together while down. The result is judged at the ports: track and discharge enables must stay low, the lamp must stay dark, and no 0x07 byte may appear. A later vector also raises off while a short is still present, to show that the lamp survives the power-down.

// File: rtl/trk_cdu_pkg.sv
package trk_cdu_pkg;

   typedef enum logic [1:0] {
      PW_OFF,
      PW_ON,
      PW_SHORTED,
      PW_CLEARED
   } pwr_st_e;

   typedef enum logic [2:0] {
      CU_IDLE,
      CU_CHARGE,
      CU_READY,
      CU_FIRE,
      CU_RECHARGE
   } cdu_st_e;

   localparam logic [7:0] MSG_FAULT      = 8'h07;
   localparam logic [7:0] MSG_FIXED      = 8'h06;
   localparam logic [4:0] MSG_POINTED_HI = 5'b00100;
   localparam logic [4:0] MSG_CHARGED_HI = 5'b00101;

   typedef struct packed {
      logic fault;
      logic fixed;
      logic pointed;
      logic charged;
   } evt_t;

endpackage

// File: rtl/trk_pwr_fsm.sv
module trk_pwr_fsm
   import trk_cdu_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_on_i,
   input  logic cmd_off_i,
   input  logic short_i,
   output logic pwr_on_o,
   output logic pwr_on_nxt_o,
   output logic lamp_o,
   output logic evt_fault_o,
   output logic evt_fixed_o
);

   pwr_st_e st_q, st_d;
   logic    on_acc;
   logic    lamp_q;

   always_comb begin
      st_d        = st_q;
      on_acc      = 1'b0;
      evt_fault_o = 1'b0;
      evt_fixed_o = 1'b0;
      if (cmd_off_i) begin
         st_d = PW_OFF;
      end else begin
         case (st_q)
            PW_OFF, PW_CLEARED: if (cmd_on_i) begin
               st_d   = PW_ON;
               on_acc = 1'b1;
            end
            PW_ON: if (short_i) begin
               st_d        = PW_SHORTED;
               evt_fault_o = 1'b1;
            end
            PW_SHORTED: if (!short_i) begin
               st_d        = PW_CLEARED;
               evt_fixed_o = 1'b1;
            end
            default: st_d = PW_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= PW_OFF;
         lamp_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (evt_fault_o)  lamp_q <= 1'b1;
         else if (on_acc)  lamp_q <= 1'b0;
      end
   end

   assign pwr_on_o     = (st_q == PW_ON);
   assign pwr_on_nxt_o = (st_d == PW_ON);
   assign lamp_o       = lamp_q;

   // R3: a short while powered leaves the powered state
   p_short_kills_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PW_ON && short_i) |=> (st_q != PW_ON));
   // R4: no return to power straight from the shorted state
   p_no_auto_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PW_SHORTED) |=> (st_q != PW_ON));
   // R9: off always lands in the unpowered state
   p_off_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_off_i |=> (st_q == PW_OFF));
   // R11: the lamp only goes dark through an on command
   p_lamp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (lamp_q && !cmd_on_i) |=> lamp_q);

endmodule

// File: rtl/trk_cdu_fsm.sv
module trk_cdu_fsm
   import trk_cdu_pkg::*;
#(
   parameter int NUM_POINTS = 6,
   parameter int IDX_W      = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  en_i,
   input  logic                  fire_req_i,
   input  logic [IDX_W-1:0]      fire_idx_i,
   input  logic                  charged_i,
   input  logic                  motion_done_i,
   output logic                  cdu_en_o,
   output logic [NUM_POINTS-1:0] drv_o,
   output logic                  err_o,
   output logic                  evt_pointed_o,
   output logic                  evt_charged_o
);

   localparam int CMP_W = IDX_W + 1;

   cdu_st_e          st_q, st_d;
   logic [IDX_W-1:0] sel_q;
   logic             idx_ok;
   logic             accept;
   logic             err_q;

   generate
      if (NUM_POINTS == (1 << IDX_W)) begin : g_full_range
         assign idx_ok = 1'b1;
      end else begin : g_range_chk
         assign idx_ok = ({1'b0, fire_idx_i} < CMP_W'(NUM_POINTS));
      end
   endgenerate

   always_comb begin
      st_d          = st_q;
      accept        = 1'b0;
      evt_pointed_o = 1'b0;
      evt_charged_o = 1'b0;
      if (!en_i) begin
         st_d = CU_IDLE;
      end else begin
         case (st_q)
            CU_IDLE:   st_d = CU_CHARGE;
            CU_CHARGE, CU_RECHARGE: if (charged_i) begin
               st_d          = CU_READY;
               evt_charged_o = 1'b1;
            end
            CU_READY: if (fire_req_i && idx_ok) begin
               st_d   = CU_FIRE;
               accept = 1'b1;
            end
            CU_FIRE: if (motion_done_i) begin
               st_d          = CU_RECHARGE;
               evt_pointed_o = 1'b1;
            end
            default: st_d = CU_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= CU_IDLE;
         sel_q <= '0;
         err_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         err_q <= fire_req_i && !accept;
         if (accept) sel_q <= fire_idx_i;
      end
   end

   assign cdu_en_o = (st_q != CU_IDLE);
   assign err_o    = err_q;

   generate
      for (genvar i = 0; i < NUM_POINTS; i++) begin : g_drv
         assign drv_o[i] = (st_q == CU_FIRE) && (sel_q == IDX_W'(i));
      end
   endgenerate

   // R8: a request while charging leaves the unit charging
   p_ignore_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && st_q == CU_CHARGE && !charged_i) |=> (st_q == CU_CHARGE));
   // R6: the chosen point stays driven until motion ends
   p_fire_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && st_q == CU_FIRE && !motion_done_i) |=> (st_q == CU_FIRE && $stable(sel_q)));

endmodule

// File: rtl/trk_stat_enc.sv
module trk_stat_enc
   import trk_cdu_pkg::*;
#(
   parameter int CDU_NUM = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  evt_t       evt_i,
   output logic       vld_o,
   output logic [7:0] byte_o
);

   localparam logic [2:0] UNIT = 3'(CDU_NUM);

   logic [7:0] code;

   always_comb begin
      if (evt_i.fault)        code = MSG_FAULT;
      else if (evt_i.fixed)   code = MSG_FIXED;
      else if (evt_i.pointed) code = {MSG_POINTED_HI, UNIT};
      else if (evt_i.charged) code = {MSG_CHARGED_HI, UNIT};
      else                    code = 8'h00;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o  <= 1'b0;
         byte_o <= 8'h00;
      end else begin
         vld_o  <= |evt_i;
         byte_o <= code;
      end
   end

   // R12: the two state machines never report in the same cycle
   p_one_evt_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(evt_i));

endmodule

// File: rtl/trk_pwr_cdu_ctrl.sv
module trk_pwr_cdu_ctrl
   import trk_cdu_pkg::*;
#(
   parameter int NUM_POINTS = 6,
   parameter int IDX_W      = (NUM_POINTS > 1) ? $clog2(NUM_POINTS) : 1,
   parameter int CDU_NUM    = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_on_i,
   input  logic                  cmd_off_i,
   input  logic                  fire_req_i,
   input  logic [IDX_W-1:0]      fire_idx_i,
   input  logic                  short_i,
   input  logic                  charged_i,
   input  logic                  motion_done_i,
   output logic                  track_en_o,
   output logic                  cdu_en_o,
   output logic [NUM_POINTS-1:0] point_drv_o,
   output logic                  fault_lamp_o,
   output logic                  req_err_o,
   output logic                  stat_vld_o,
   output logic [7:0]            stat_byte_o
);

   generate
      if (NUM_POINTS < 1 || NUM_POINTS > 64) begin : g_bad_points
         $error("NUM_POINTS must lie in 1..64");
      end
      if ((1 << IDX_W) < NUM_POINTS) begin : g_bad_idx
         $error("IDX_W too narrow for NUM_POINTS");
      end
      if (CDU_NUM < 0 || CDU_NUM > 7) begin : g_bad_unit
         $error("CDU_NUM must fit in three bits");
      end
   endgenerate

   logic pwr_on_nxt;
   evt_t evt;

   trk_pwr_fsm u_pwr (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_on_i     (cmd_on_i),
      .cmd_off_i    (cmd_off_i),
      .short_i      (short_i),
      .pwr_on_o     (track_en_o),
      .pwr_on_nxt_o (pwr_on_nxt),
      .lamp_o       (fault_lamp_o),
      .evt_fault_o  (evt.fault),
      .evt_fixed_o  (evt.fixed)
   );

   trk_cdu_fsm #(
      .NUM_POINTS (NUM_POINTS),
      .IDX_W      (IDX_W)
   ) u_cdu (
      .clk           (clk),
      .rst_n         (rst_n),
      .en_i          (pwr_on_nxt),
      .fire_req_i    (fire_req_i),
      .fire_idx_i    (fire_idx_i),
      .charged_i     (charged_i),
      .motion_done_i (motion_done_i),
      .cdu_en_o      (cdu_en_o),
      .drv_o         (point_drv_o),
      .err_o         (req_err_o),
      .evt_pointed_o (evt.pointed),
      .evt_charged_o (evt.charged)
   );

   trk_stat_enc #(
      .CDU_NUM (CDU_NUM)
   ) u_enc (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (evt),
      .vld_o  (stat_vld_o),
      .byte_o (stat_byte_o)
   );

   // R2: a drive is only ever live with track and unit powered
   p_drv_needs_power_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|point_drv_o) |-> (track_en_o && cdu_en_o));
   // R6: never more than one point motor driven
   p_drv_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(point_drv_o));
   // R10: off alongside a short never produces a fault report
   p_off_beats_short_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_off_i && track_en_o && short_i) |=> !(stat_vld_o && stat_byte_o == MSG_FAULT));

endmodule

// File: tb/trk_pwr_cdu_ctrl_tb.sv
module trk_pwr_cdu_ctrl_tb;

   localparam int NP = 6;
   localparam int IW = 3;

   typedef struct packed {
      logic          on;
      logic          off;
      logic          fire;
      logic [2:0]    idx;
      logic          sh;
      logic          chg;
      logic          done;
      logic          trk;
      logic          cdu;
      logic [NP-1:0] drv;
      logic          lamp;
      logic          err;
      logic          vld;
      logic [7:0]    code;
      logic [3:0]    req;
   } vec_t;

   localparam int NV = 29;
   localparam logic H = 1'b1;
   localparam logic L = 1'b0;

   // fields: on off fire idx sh chg done | trk cdu drv lamp err vld code | req
   localparam vec_t VECS [NV] = '{
      '{L,L,H,3'd0,L,L,L, L,L,6'b000000,L,H,L,8'h00,4'd8 },  // R8 fire while off
      '{H,L,L,3'd0,L,L,L, H,H,6'b000000,L,L,L,8'h00,4'd2 },  // R2 on
      '{L,L,H,3'd1,L,L,L, H,H,6'b000000,L,H,L,8'h00,4'd8 },  // R8 fire while charging
      '{L,L,L,3'd0,L,H,L, H,H,6'b000000,L,L,H,8'h28,4'd5 },  // R5 charged
      '{L,L,L,3'd0,L,L,L, H,H,6'b000000,L,L,L,8'h00,4'd12},  // R12 strobe one cycle
      '{L,L,H,3'd2,L,L,L, H,H,6'b000100,L,L,L,8'h00,4'd6 },  // R6 fire point 2
      '{L,L,L,3'd0,L,L,L, H,H,6'b000100,L,L,L,8'h00,4'd6 },  // R6 drive holds
      '{L,L,H,3'd3,L,L,L, H,H,6'b000100,L,H,L,8'h00,4'd8 },  // R8 fire while firing
      '{L,L,L,3'd0,L,L,H, H,H,6'b000000,L,L,H,8'h20,4'd6 },  // R6 pointed
      '{L,L,H,3'd0,L,L,L, H,H,6'b000000,L,H,L,8'h00,4'd8 },  // R8 fire while recharging
      '{L,L,L,3'd0,L,H,L, H,H,6'b000000,L,L,H,8'h28,4'd7 },  // R7 recharged
      '{L,L,H,3'd6,L,L,L, H,H,6'b000000,L,H,L,8'h00,4'd8 },  // R8 index out of range
      '{L,L,H,3'd5,L,L,L, H,H,6'b100000,L,L,L,8'h00,4'd6 },  // R6 fire top point
      '{L,L,L,3'd0,H,L,L, L,L,6'b000000,H,L,H,8'h07,4'd3 },  // R3 short
      '{H,L,L,3'd0,H,L,L, L,L,6'b000000,H,L,L,8'h00,4'd4 },  // R4 on ignored while shorted
      '{L,L,L,3'd0,L,L,L, L,L,6'b000000,H,L,H,8'h06,4'd4 },  // R4 fixed
      '{L,L,L,3'd0,L,L,L, L,L,6'b000000,H,L,L,8'h00,4'd4 },  // R4 no auto restore
      '{H,L,L,3'd0,L,L,L, H,H,6'b000000,L,L,L,8'h00,4'd11},  // R11 on clears lamp
      '{L,L,L,3'd0,L,H,L, H,H,6'b000000,L,L,H,8'h28,4'd5 },  // R5 charged again
      '{L,H,L,3'd0,H,L,L, L,L,6'b000000,L,L,L,8'h00,4'd10},  // R10 off beats short
      '{H,H,L,3'd0,L,L,L, L,L,6'b000000,L,L,L,8'h00,4'd10},  // R10 off beats on
      '{H,L,L,3'd0,L,L,L, H,H,6'b000000,L,L,L,8'h00,4'd2 },  // R2 on
      '{L,L,L,3'd0,H,L,L, L,L,6'b000000,H,L,H,8'h07,4'd3 },  // R3 short while charging
      '{L,H,L,3'd0,H,L,L, L,L,6'b000000,H,L,L,8'h00,4'd11},  // R11 off keeps lamp
      '{H,L,L,3'd0,L,L,L, H,H,6'b000000,L,L,L,8'h00,4'd11},  // R11 on clears lamp
      '{L,L,L,3'd0,L,H,L, H,H,6'b000000,L,L,H,8'h28,4'd5 },  // R5
      '{L,L,H,3'd0,L,L,L, H,H,6'b000001,L,L,L,8'h00,4'd6 },  // R6 fire point 0
      '{L,H,L,3'd0,L,L,L, L,L,6'b000000,L,L,L,8'h00,4'd9 },  // R9 off while firing
      '{L,L,L,3'd0,L,L,H, L,L,6'b000000,L,L,L,8'h00,4'd9 }   // R9 done ignored while off
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_on, cmd_off, fire_req, short_in, charged, motion_done;
   logic [IW-1:0] fire_idx;
   logic          track_en, cdu_en, fault_lamp, req_err, stat_vld;
   logic [NP-1:0] point_drv;
   logic [7:0]    stat_byte;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   trk_pwr_cdu_ctrl #(.NUM_POINTS(NP)) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_on_i      (cmd_on),
      .cmd_off_i     (cmd_off),
      .fire_req_i    (fire_req),
      .fire_idx_i    (fire_idx),
      .short_i       (short_in),
      .charged_i     (charged),
      .motion_done_i (motion_done),
      .track_en_o    (track_en),
      .cdu_en_o      (cdu_en),
      .point_drv_o   (point_drv),
      .fault_lamp_o  (fault_lamp),
      .req_err_o     (req_err),
      .stat_vld_o    (stat_vld),
      .stat_byte_o   (stat_byte)
   );

   function automatic logic [18:0] observed();
      return {track_en, cdu_en, point_drv, fault_lamp, req_err, stat_vld, stat_byte};
   endfunction

   task automatic check(input logic [18:0] exp, input int rq, input string what);
      total++;
      if (observed() !== exp) begin
         bad++;
         $display("FAIL R%0d %s: got %b expected %b", rq, what, observed(), exp);
      end
   endtask

   task automatic drive(input vec_t v);
      cmd_on      = v.on;
      cmd_off     = v.off;
      fire_req    = v.fire;
      fire_idx    = v.idx;
      short_in    = v.sh;
      charged     = v.chg;
      motion_done = v.done;
   endtask

   task automatic idle_inputs();
      cmd_on = 0; cmd_off = 0; fire_req = 0; fire_idx = '0;
      short_in = 0; charged = 0; motion_done = 0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle_inputs();
      repeat (3) @(negedge clk);
      check(19'd0, 1, "R1 outputs in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check(19'd0, 1, "R1 idle after reset");

      for (int i = 0; i < NV; i++) begin
         drive(VECS[i]);
         @(negedge clk);
         check({VECS[i].trk, VECS[i].cdu, VECS[i].drv, VECS[i].lamp,
                VECS[i].err, VECS[i].vld, VECS[i].code},
               int'(VECS[i].req), $sformatf("vector %0d", i));
      end

      // R1: reset while a point is being fired clears everything at once
      idle_inputs();
      cmd_on = 1; @(negedge clk); cmd_on = 0;
      charged = 1; @(negedge clk); charged = 0;
      fire_req = 1; fire_idx = 3'd4; @(negedge clk); fire_req = 0;
      check({1'b1, 1'b1, 6'b010000, 1'b0, 1'b0, 1'b0, 8'h00}, 6, "fire point 4");
      #1 rst_n = 1'b0;
      #1 check(19'd0, 1, "R1 async reset mid-firing");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(19'd0, 1, "R1 stays down after reset");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule